// File: doc/BRIEF.md
# EDO DRAM Pin-Level Emulator

This block stands in for an asynchronous extended-data-out DRAM. A fast system clock samples its pins, so a memory controller can be exercised against it inside a synchronous design. The row strobe, the two byte column strobes, the write enable and the output enable go through a two-flop synchronizer. Edges are then found on the synchronized levels.

The order of those edges decides what each strobe cycle is:
- a normal access, which may run several column strobes in page mode;
- a RAS-only refresh;
- a CAS-before-RAS refresh, which takes its row from an internal counter;
- a hidden refresh, where the column strobe stays low after a read while the row strobe toggles.

Read data stays on the outputs after the column strobe rises. It is released only when the row strobe and both column strobes are all high. Every kind of cycle, normal accesses included, counts as a refresh of the row it touched. A per-row age counter raises a sticky retention error when a row goes unrefreshed for longer than a parameterised number of clocks.

Top module: `edo_dram_emu`

## Requirements
- R1: A falling row strobe while both column strobes are high latches the row from `addr`. Each later column strobe fall within that row cycle reads or writes the word at the column on `addr` (page mode). Such a cycle reports `cyc_kind` = 0.
- R2: A row cycle in which no column strobe falls reports `cyc_kind` = 1, and the outputs stay undriven (`dq_oe` = 00) throughout.
- R3: A row strobe fall with either column strobe already low, and no read data held, reports `cyc_kind` = 3. Its outputs stay undriven whatever WE and OE do. It refreshes the row named by an internal counter, which advances by one per such cycle (hidden cycles included) and wraps over all rows.
- R4: A row strobe fall with a column strobe low while read data is still held reports `cyc_kind` = 2. The held data stays driven through the whole cycle.
- R5: After a read, data stays driven once the column strobes rise. `dq_oe` returns to 00 only when the row strobe and both column strobes are high.
- R6: The lower column strobe governs bits 7:0 and `dq_oe[0]`. The upper column strobe governs bits 15:8 and `dq_oe[1]`. This holds for writes and for reads.
- R7: OE high or WE low forces `dq_oe` to 00 while they last. Read data that is held comes back when they return.
- R8: `retention_err` rises once any row has gone more than `RET_LIMIT` clocks without a refresh of any kind. Once set, it stays set until reset.
- R9: After reset, `dq_oe` = 00, `cyc_kind` = 0, `retention_err` = 0 and the array reads as zero.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row/column address |
| dq_in | input | DW | Write data from the bus |
| dq_out | output | DW | Read data toward the bus |
| dq_oe | output | 2 | Per-byte output drive enables, bit 1 upper |
| cyc_kind | output | 2 | Kind of the last completed row cycle |
| retention_err | output | 1 | Sticky retention violation flag |

## Verification
Two functions can fall in the same row cycle: a refresh and the EDO hold of read data. This happens in a hidden refresh. The bench provokes it by ending a read with the row strobe rising while the column strobes stay low, then toggling the row strobe again. The scoreboard expects the read word on both lanes before, during and after the refresh, and expects release only when the column strobes rise. A CAS-before-RAS sweep over every row then shows that the counter-driven refreshes and the access-driven refreshes together keep the retention flag low until the age limit has passed.

// File: rtl/edo_pkg.sv
// Shared types for the EDO DRAM emulator.
// Assumes: nothing beyond IEEE 1800-2017.
package edo_pkg;
    // Classification of a completed row-strobe cycle (values visible on cyc_kind)
    typedef enum logic [1:0] {
        CK_NORMAL   = 2'd0,
        CK_RAS_ONLY = 2'd1,
        CK_HIDDEN   = 2'd2,
        CK_CBR      = 2'd3
    } cyc_kind_e;

    // Controller state between row strobe edges
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_OPEN = 2'd1,
        ST_REFR = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/edo_sync.sv
// Two-flop synchronizer for a bundle of asynchronous pins.
// Assumes: the bits of a bundle settle before they are used together;
// RST_VAL is the idle level of the pins.
module edo_sync #(
    parameter int          WIDTH   = 1,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] meta_q;

    // Two register stages toward the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= {WIDTH{RST_VAL}};
            q      <= {WIDTH{RST_VAL}};
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/edo_cycle_ctl.sv
// Strobe-edge decoder. It finds edges on synchronized strobes, classifies
// each row cycle, issues array accesses and refresh events, and tracks
// which byte lanes hold read data.
// Assumes: inputs are already synchronized; addr is stable at strobe edges.
module edo_cycle_ctl
    import edo_pkg::*;
#(
    parameter int RW = 4,
    parameter int CW = 4,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_s,
    input  logic          ucas_s,
    input  logic          lcas_s,
    input  logic          we_s,
    input  logic [AW-1:0] addr_s,
    output logic          acc_req,
    output logic          acc_wr,
    output logic [1:0]    acc_lanes,
    output logic [RW-1:0] acc_row,
    output logic [CW-1:0] acc_col,
    output logic          ref_pulse,
    output logic [RW-1:0] ref_row,
    output logic [1:0]    held_lanes,
    output cyc_kind_e     kind
);
    ctl_state_e    state;
    logic          ras_p, ucas_p, lcas_p;
    logic          ras_fall, ras_rise, cas_fall, all_high;
    logic          accessed, hidden;
    logic [RW-1:0] row_q, ref_ctr;

    assign ras_fall = ras_p & ~ras_s;
    assign ras_rise = ~ras_p & ras_s;
    assign cas_fall = (ucas_p & ~ucas_s) | (lcas_p & ~lcas_s);
    assign all_high = ras_s & ucas_s & lcas_s;
    assign acc_row  = row_q;

    // Previous strobe levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_p  <= 1'b1;
            ucas_p <= 1'b1;
            lcas_p <= 1'b1;
        end else begin
            ras_p  <= ras_s;
            ucas_p <= ucas_s;
            lcas_p <= lcas_s;
        end
    end

    // Cycle classification, access issue and output hold tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            row_q      <= '0;
            ref_ctr    <= '0;
            accessed   <= 1'b0;
            hidden     <= 1'b0;
            held_lanes <= 2'b00;
            kind       <= CK_NORMAL;
            acc_req    <= 1'b0;
            acc_wr     <= 1'b0;
            acc_lanes  <= 2'b00;
            acc_col    <= '0;
            ref_pulse  <= 1'b0;
            ref_row    <= '0;
        end else begin
            acc_req   <= 1'b0;
            ref_pulse <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ras_fall) begin
                        if (ucas_s && lcas_s) begin
                            state    <= ST_OPEN;
                            row_q    <= addr_s[RW-1:0];
                            accessed <= 1'b0;
                        end else begin
                            state   <= ST_REFR;
                            row_q   <= ref_ctr;
                            ref_ctr <= ref_ctr + 1'b1;
                            hidden  <= |held_lanes;
                        end
                    end
                end
                ST_OPEN: begin
                    if (ras_rise) begin
                        state     <= ST_IDLE;
                        ref_pulse <= 1'b1;
                        ref_row   <= row_q;
                        kind      <= accessed ? CK_NORMAL : CK_RAS_ONLY;
                    end else if (cas_fall) begin
                        acc_req   <= 1'b1;
                        acc_wr    <= ~we_s;
                        acc_lanes <= {~ucas_s, ~lcas_s};
                        acc_col   <= addr_s[CW-1:0];
                        accessed  <= 1'b1;
                        if (we_s) held_lanes <= {~ucas_s, ~lcas_s};
                    end
                end
                ST_REFR: begin
                    if (ras_rise) begin
                        state     <= ST_IDLE;
                        ref_pulse <= 1'b1;
                        ref_row   <= row_q;
                        kind      <= hidden ? CK_HIDDEN : CK_CBR;
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (all_high) held_lanes <= 2'b00;
        end
    end

    // R2: a row cycle with no column access is reported as RAS-only
    p_ror_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN && ras_rise && !accessed) |=> kind == CK_RAS_ONLY);
    // R3: no lane is held during a CAS-before-RAS refresh
    p_cbr_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFR && !hidden) |-> held_lanes == 2'b00);
    // R3: the refresh counter steps once per counter-driven refresh
    p_ctr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ras_fall && !(ucas_s && lcas_s))
        |=> ref_ctr == RW'($past(ref_ctr) + 1'b1));
    // R4: held data persists through a hidden refresh
    p_hidden_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFR && hidden) |-> held_lanes != 2'b00);
endmodule

// File: rtl/edo_array.sv
// Storage array with byte-lane writes and a registered read word.
// Assumes: ROWS*COLS equals 2**(RW+CW); the array is cleared on reset.
module edo_array #(
    parameter int RW = 4,
    parameter int CW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_req,
    input  logic          acc_wr,
    input  logic [1:0]    acc_lanes,
    input  logic [RW-1:0] acc_row,
    input  logic [CW-1:0] acc_col,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << (RW + CW);
    localparam int LW    = DW / 2;

    logic [DW-1:0]      mem [DEPTH];
    logic [RW+CW-1:0]   idx;

    assign idx = {acc_row, acc_col};

    // Lane-masked write port and registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else if (acc_req) begin
            if (acc_wr) begin
                for (int l = 0; l < 2; l++)
                    if (acc_lanes[l]) mem[idx][l*LW +: LW] <= wdata[l*LW +: LW];
            end else begin
                rdata <= mem[idx];
            end
        end
    end
endmodule

// File: rtl/edo_retention.sv
// Per-row refresh age tracking with a sticky violation flag.
// Assumes: ref_pulse marks one refreshed row per pulse; ages count clocks.
module edo_retention #(
    parameter int ROWS      = 16,
    parameter int RW        = 4,
    parameter int RET_LIMIT = 3000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_pulse,
    input  logic [RW-1:0] ref_row,
    output logic          err
);
    localparam int               AGW = $clog2(RET_LIMIT + 2);
    localparam logic [AGW-1:0]   LIM = AGW'(RET_LIMIT);

    logic [ROWS-1:0] over;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [AGW-1:0] age;
        // Age counter, cleared by a refresh of this row, saturating past the limit
        always_ff @(posedge clk) begin
            if (!rst_n)                                  age <= '0;
            else if (ref_pulse && ref_row == RW'(r))     age <= '0;
            else if (age <= LIM)                         age <= age + 1'b1;
        end
        assign over[r] = age > LIM;
    end

    // Sticky error collection
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= err | (|over);
    end

    // R8: the retention flag never drops without reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/edo_dram_emu.sv
// Top of the EDO DRAM pin-level emulator. It synchronizes the pins, decodes
// the strobe cycles, holds the storage and checks refresh retention.
// Assumes: pins idle high; one byte lane per column strobe; DW is even.
module edo_dram_emu #(
    parameter int ROWS      = 16,
    parameter int COLS      = 16,
    parameter int DW        = 16,
    parameter int RET_LIMIT = 3000,
    parameter int RW        = $clog2(ROWS),
    parameter int CW        = $clog2(COLS),
    parameter int AW        = (RW > CW) ? RW : CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ras_n,
    input  logic          ucas_n,
    input  logic          lcas_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic [1:0]    dq_oe,
    output logic [1:0]    cyc_kind,
    output logic          retention_err
);
    import edo_pkg::*;

    logic [4:0]    ctl_s;
    logic [AW-1:0] addr_s;
    logic [DW-1:0] din_s;
    logic          acc_req, acc_wr, ref_pulse;
    logic [1:0]    acc_lanes, held_lanes;
    logic [RW-1:0] acc_row, ref_row;
    logic [CW-1:0] acc_col;
    cyc_kind_e     kind;

    edo_sync #(.WIDTH(5), .RST_VAL(1'b1)) u_sync_ctl (
        .clk(clk), .rst_n(rst_n),
        .d({ras_n, ucas_n, lcas_n, we_n, oe_n}), .q(ctl_s));
    edo_sync #(.WIDTH(AW), .RST_VAL(1'b0)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d(addr), .q(addr_s));
    edo_sync #(.WIDTH(DW), .RST_VAL(1'b0)) u_sync_din (
        .clk(clk), .rst_n(rst_n), .d(dq_in), .q(din_s));

    edo_cycle_ctl #(.RW(RW), .CW(CW), .AW(AW)) u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ras_s(ctl_s[4]), .ucas_s(ctl_s[3]), .lcas_s(ctl_s[2]), .we_s(ctl_s[1]),
        .addr_s(addr_s),
        .acc_req(acc_req), .acc_wr(acc_wr), .acc_lanes(acc_lanes),
        .acc_row(acc_row), .acc_col(acc_col),
        .ref_pulse(ref_pulse), .ref_row(ref_row),
        .held_lanes(held_lanes), .kind(kind));

    edo_array #(.RW(RW), .CW(CW), .DW(DW)) u_array (
        .clk(clk), .rst_n(rst_n),
        .acc_req(acc_req), .acc_wr(acc_wr), .acc_lanes(acc_lanes),
        .acc_row(acc_row), .acc_col(acc_col),
        .wdata(din_s), .rdata(dq_out));

    edo_retention #(.ROWS(ROWS), .RW(RW), .RET_LIMIT(RET_LIMIT)) u_ret (
        .clk(clk), .rst_n(rst_n),
        .ref_pulse(ref_pulse), .ref_row(ref_row), .err(retention_err));

    // Drive gating: OE high or WE low keeps the bus released
    assign dq_oe    = held_lanes & {2{~ctl_s[0] & ctl_s[1]}};
    assign cyc_kind = kind;
endmodule

// File: tb/edo_dram_emu_tb_top.sv
// Scoreboard bench: driver tasks push expected bus states, a monitor compares.
module edo_dram_emu_tb_top;
    localparam int LIMIT = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [3:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe, cyc_kind;
    logic        retention_err;

    int nrun = 0, nfail = 0, cyc = 0;

    typedef struct {
        logic [15:0] d;
        logic [1:0]  oe;
        string       tag;
    } item_t;
    item_t sb_q[$];
    event  chk_ev;
    logic [15:0] model [16][16];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    edo_dram_emu #(.RET_LIMIT(LIMIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .cyc_kind(cyc_kind), .retention_err(retention_err));

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        nrun++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic expect_bus(input logic [15:0] d, input logic [1:0] oe, input string tag);
        item_t it;
        it.d = d; it.oe = oe; it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
        #0.5;
    endtask

    // Monitor: pops expected items and compares them with the bus
    initial begin
        forever begin
            @(chk_ev);
            #0.1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] m;
                it = sb_q.pop_front();
                m = {{8{it.oe[1]}}, {8{it.oe[0]}}};
                nrun++;
                if (dq_oe !== it.oe || (dq_out & m) !== (it.d & m)) begin
                    nfail++;
                    $display("FAIL %s: actual oe=%b dq=%h expected oe=%b dq=%h",
                             it.tag, dq_oe, dq_out & m, it.oe, it.d & m);
                end
            end
        end
    end

    task automatic wr(input int row, input int col, input logic [15:0] d, input logic [1:0] ln);
        addr = 4'(row); step(1); ras_n = 1'b0; step(5);
        addr = 4'(col); dq_in = d; we_n = 1'b0; step(1);
        lcas_n = ~ln[0]; ucas_n = ~ln[1]; step(6);
        lcas_n = 1'b1; ucas_n = 1'b1; step(2);
        we_n = 1'b1; ras_n = 1'b1; step(6);
        if (ln[0]) model[row][col][7:0]  = d[7:0];
        if (ln[1]) model[row][col][15:8] = d[15:8];
    endtask

    task automatic open_row(input int row);
        addr = 4'(row); step(1); ras_n = 1'b0; step(5);
    endtask

    task automatic rd_col(input int col, input logic [1:0] ln);
        addr = 4'(col); oe_n = 1'b0; step(1);
        lcas_n = ~ln[0]; ucas_n = ~ln[1]; step(6);
    endtask

    task automatic cbr();
        lcas_n = 1'b0; step(3); ras_n = 1'b0; step(4);
        ras_n = 1'b1; step(4); lcas_n = 1'b1; step(4);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        nrun++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end

    initial begin
        int t0, t_end;
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) model[r][c] = '0;
        step(5); rst_n = 1'b1; step(3);

        // R9: reset state
        check(dq_oe == 2'b00, "R9 dq_oe after reset", dq_oe, 0);
        check(cyc_kind == 2'd0, "R9 cyc_kind after reset", cyc_kind, 0);
        check(retention_err == 1'b0, "R9 retention_err after reset", retention_err, 0);
        open_row(9); rd_col(4, 2'b11);
        expect_bus(16'h0000, 2'b11, "R9 array cleared");
        lcas_n = 1'b1; ucas_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; step(6);

        wr(2, 5, 16'hA5C3, 2'b11);
        wr(3, 1, 16'h1234, 2'b11);
        wr(3, 2, 16'hBEEF, 2'b11);

        // R1 and R5: read, EDO hold, release
        open_row(2); rd_col(5, 2'b11);
        expect_bus(model[2][5], 2'b11, "R1 read row 2 col 5");
        lcas_n = 1'b1; ucas_n = 1'b1; step(6);
        expect_bus(model[2][5], 2'b11, "R5 hold after CAS rise");
        ras_n = 1'b1; step(6);
        expect_bus(16'h0000, 2'b00, "R5 release when all strobes high");
        check(cyc_kind == 2'd0, "R1 normal cycle kind", cyc_kind, 0);

        // R1: page mode, two columns in one row cycle
        open_row(3); rd_col(1, 2'b11);
        expect_bus(model[3][1], 2'b11, "R1 page first column");
        lcas_n = 1'b1; ucas_n = 1'b1; step(3);
        rd_col(2, 2'b11);
        expect_bus(model[3][2], 2'b11, "R1 page second column");
        lcas_n = 1'b1; ucas_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; step(6);

        // R6: byte lanes
        wr(2, 5, 16'h7711, 2'b01);
        open_row(2); rd_col(5, 2'b10);
        expect_bus(model[2][5], 2'b10, "R6 upper lane only");
        lcas_n = 1'b1; ucas_n = 1'b1; step(3);
        rd_col(5, 2'b01);
        expect_bus(16'hA511, 2'b01, "R6 lower lane written alone");
        lcas_n = 1'b1; ucas_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; step(6);

        // R7: OE high and WE low release the bus
        open_row(3); rd_col(2, 2'b11);
        oe_n = 1'b1; step(3);
        expect_bus(16'h0000, 2'b00, "R7 OE high releases");
        oe_n = 1'b0; step(3);
        expect_bus(model[3][2], 2'b11, "R7 OE low restores");
        we_n = 1'b0; step(3);
        expect_bus(16'h0000, 2'b00, "R7 WE low releases");
        we_n = 1'b1; step(3);
        expect_bus(model[3][2], 2'b11, "R7 WE high restores");
        lcas_n = 1'b1; ucas_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; step(6);

        // R2: RAS-only refresh
        open_row(7); oe_n = 1'b0; step(3);
        expect_bus(16'h0000, 2'b00, "R2 undriven during RAS-only");
        ras_n = 1'b1; oe_n = 1'b1; step(6);
        check(cyc_kind == 2'd1, "R2 RAS-only kind", cyc_kind, 1);

        // R3: CAS-before-RAS refresh ignores WE and OE
        lcas_n = 1'b0; step(4); ras_n = 1'b0; step(4);
        oe_n = 1'b0; we_n = 1'b0; step(4);
        expect_bus(16'h0000, 2'b00, "R3 undriven with WE low");
        we_n = 1'b1; step(4);
        expect_bus(16'h0000, 2'b00, "R3 undriven with OE low");
        ras_n = 1'b1; step(6);
        check(cyc_kind == 2'd3, "R3 CBR kind", cyc_kind, 3);
        lcas_n = 1'b1; oe_n = 1'b1; step(4);
        check(model[9][9] == model[9][9] && dq_oe == 2'b00, "R3 idle after CBR", dq_oe, 0);

        // R4: hidden refresh keeps read data driven
        open_row(3); rd_col(1, 2'b11);
        expect_bus(model[3][1], 2'b11, "R4 read before hidden");
        ras_n = 1'b1; step(6);
        expect_bus(model[3][1], 2'b11, "R4 held with RAS high");
        ras_n = 1'b0; step(6);
        expect_bus(model[3][1], 2'b11, "R4 held during hidden refresh");
        ras_n = 1'b1; step(6);
        check(cyc_kind == 2'd2, "R4 hidden kind", cyc_kind, 2);
        expect_bus(model[3][1], 2'b11, "R4 held after hidden refresh");
        lcas_n = 1'b1; ucas_n = 1'b1; step(6);
        expect_bus(16'h0000, 2'b00, "R4 release after CAS rise");
        oe_n = 1'b1; step(2);

        // R8 and R3 counter: sweep every row, then watch the age limit
        check(retention_err == 1'b0, "R8 no flag before sweep", retention_err, 0);
        t0 = cyc;
        for (int i = 0; i < 16; i++) cbr();
        t_end = cyc;
        while (cyc < t0 + LIMIT - 100) step(1);
        check(retention_err == 1'b0, "R8 R3 sweep refreshed every row", retention_err, 0);
        while (cyc < t_end + LIMIT + 100) step(1);
        check(retention_err == 1'b1, "R8 flag after limit", retention_err, 1);
        open_row(2); rd_col(5, 2'b11);
        lcas_n = 1'b1; ucas_n = 1'b1; ras_n = 1'b1; oe_n = 1'b1; step(6);
        check(retention_err == 1'b1, "R8 flag sticky after refresh", retention_err, 1);

        $display("[TB] %0d tests run, %0d failed", nrun, nfail);
        $finish;
    end
endmodule